// File: doc/BRIEF.md
# Associative Rename Buffer Array

This block holds in-flight register results for an out-of-order core whose operands are read at issue. There is no separate map from architectural to physical registers. Each buffer entry records the architectural register it stands for, and a source operand is resolved by searching every entry for that register. Renaming and operand reading are therefore one step: an instruction's sources either come back with a finished value, come back as the index of the entry that will produce the value, or miss. A miss means the architectural register file holds the current copy.

Entries are handed out in program order from a circular queue. When a new entry is created for a register, it takes over as the newest copy of that register, and older live copies of it stop answering lookups. Execution units deliver results by entry index. Finished entries at the head of the queue drain to the architectural file, several per cycle and strictly in order. A flush discards every live entry at once.

Top module: `assoc_rename_buf`

## Requirements
- R1: After reset the array is empty: `alloc_full` is 0, `alloc_tag` is 0, every `src_hit` bit is 0 and every `ret_vld` bit is 0.
- R2: Allocation fills entries in circular order starting at index 0, and `alloc_tag` names the entry the next allocation takes. `alloc_full` is 1 exactly when DEPTH entries are live. An allocation requested while full has no effect.
- R3: A source lookup of a register with a live, newest entry whose result is not yet written returns `src_hit`=1, `src_rdy`=0 and that entry's index on `src_tag`.
- R4: A write on `wb_tag` to a live entry makes later lookups of that entry return `src_rdy`=1 and the written data on `src_val`. A write to an entry that is not live is ignored. `src_val` reads 0 whenever `src_rdy` is 0.
- R5: When a register has several live entries, lookups return only the most recently allocated one.
- R6: A lookup of a register with no live entry returns `src_hit`=0, `src_rdy`=0, and 0 on `src_tag`, so the caller reads the architectural file.
- R7: Each cycle, up to RETW entries retire from the head in order. Slot k (lane k of `ret_vld`, `ret_reg`, `ret_data`) is valid only if slots 0..k-1 are valid and the entry at head+k is live and has its result. Retired entries are freed at the clock edge.
- R8: Once the newest entry of a register has retired, lookups of that register miss.
- R9: A flush frees all entries and resets the queue to index 0. In a flush cycle nothing retires and nothing is allocated.
- R10: Lookups reflect the state held before the current edge. An allocation or write made in the same cycle shows up in lookups only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Discard all live entries |
| alloc_en | input | 1 | Request an entry for a destination |
| alloc_dst | input | AW | Destination architectural register |
| alloc_full | output | 1 | All entries live |
| alloc_tag | output | IW | Index the next allocation receives |
| src_reg | input | NSRC*AW | Source registers, lane s at bits s*AW |
| src_hit | output | NSRC | Source maps to a live entry |
| src_rdy | output | NSRC | Mapped entry holds its result |
| src_tag | output | NSRC*IW | Mapped entry index per lane |
| src_val | output | NSRC*DW | Result value per lane |
| wb_en | input | 1 | Result write strobe |
| wb_tag | input | IW | Entry receiving the result |
| wb_data | input | DW | Result value |
| ret_vld | output | RETW | Retirement lane valid |
| ret_reg | output | RETW*AW | Architectural register per lane |
| ret_data | output | RETW*DW | Value per lane |

## Verification
The bench goes after register aliasing. It allocates the same register twice and checks that lookups follow only the newer entry; a design that failed to clear the older copy's newest flag would return two hits or the stale index. It writes a result to the newer copy while the head is still pending, to show that retirement stalls behind an unready head rather than skipping it. It then confirms that retiring the newest copy turns later lookups into misses. Further cases cover:
- an allocation attempted while full, which must not overwrite the head entry;
- a write to a freed entry, which must not mark its next owner as ready;
- lookups in the cycle of a flush, allocation or write, which must show the old state.

A long random run compares every lookup lane and every retire lane against a queue model kept in the bench.

// File: rtl/assoc_rename_buf.sv
module assoc_rename_buf #(
  parameter int DEPTH = 8,
  parameter int AREGS = 32,
  parameter int DW    = 32,
  parameter int NSRC  = 2,
  parameter int RETW  = 2,
  localparam int AW   = $clog2(AREGS),
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               alloc_en,
  input  logic [AW-1:0]      alloc_dst,
  output logic               alloc_full,
  output logic [IW-1:0]      alloc_tag,
  input  logic [NSRC*AW-1:0] src_reg,
  output logic [NSRC-1:0]    src_hit,
  output logic [NSRC-1:0]    src_rdy,
  output logic [NSRC*IW-1:0] src_tag,
  output logic [NSRC*DW-1:0] src_val,
  input  logic               wb_en,
  input  logic [IW-1:0]      wb_tag,
  input  logic [DW-1:0]      wb_data,
  output logic [RETW-1:0]    ret_vld,
  output logic [RETW*AW-1:0] ret_reg,
  output logic [RETW*DW-1:0] ret_data
);

  logic [DEPTH-1:0]          ent_v, ent_lat, ent_vv;
  logic [DEPTH-1:0][AW-1:0]  ent_dst;
  logic [DEPTH-1:0][DW-1:0]  ent_val;
  logic [IW-1:0]             head, tail;
  logic [CW-1:0]             cnt;
  logic [NSRC-1:0][DEPTH-1:0] hitv;
  logic [CW-1:0]             nret;
  logic                      do_alloc;

  assign alloc_full = (cnt == CW'(DEPTH));
  assign alloc_tag  = tail;
  assign do_alloc   = alloc_en & ~alloc_full & ~flush;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [IW-1:0] tg;
    logic [DW-1:0] vl;
    logic          rd;
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign hitv[s][e] = ent_v[e] & ent_lat[e] & (ent_dst[e] == src_reg[s*AW +: AW]);
    end
    always_comb begin
      tg = '0;
      vl = '0;
      rd = 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        if (hitv[s][e]) begin
          tg = tg | IW'(e);
          rd = rd | ent_vv[e];
          if (ent_vv[e]) vl = vl | ent_val[e];
        end
      end
    end
    assign src_hit[s]           = |hitv[s];
    assign src_rdy[s]           = rd;
    assign src_tag[s*IW +: IW]  = tg;
    assign src_val[s*DW +: DW]  = vl;
  end

  for (genvar k = 0; k < RETW; k++) begin : g_ret
    logic [IW-1:0] idx;
    logic          prev;
    assign idx = head + IW'(k);
    if (k == 0) begin : g_first
      assign prev = ~flush;
    end else begin : g_next
      assign prev = ret_vld[k-1];
    end
    assign ret_vld[k]             = prev & ent_v[idx] & ent_vv[idx];
    assign ret_reg[k*AW +: AW]    = ent_dst[idx];
    assign ret_data[k*DW +: DW]   = ent_val[idx];
  end

  always_comb begin
    nret = '0;
    for (int k = 0; k < RETW; k++) nret = nret + CW'(ret_vld[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_lat <= '0;
      ent_vv  <= '0;
      ent_dst <= '0;
      ent_val <= '0;
      head    <= '0;
      tail    <= '0;
      cnt     <= '0;
    end else if (flush) begin
      ent_v <= '0;
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
    end else begin
      if (wb_en && ent_v[wb_tag]) begin
        ent_vv[wb_tag]  <= 1'b1;
        ent_val[wb_tag] <= wb_data;
      end
      for (int k = 0; k < RETW; k++)
        if (ret_vld[k]) ent_v[head + IW'(k)] <= 1'b0;
      if (do_alloc) begin
        for (int e = 0; e < DEPTH; e++)
          if (ent_v[e] && ent_dst[e] == alloc_dst) ent_lat[e] <= 1'b0;
        ent_v[tail]   <= 1'b1;
        ent_lat[tail] <= 1'b1;
        ent_vv[tail]  <= 1'b0;
        ent_dst[tail] <= alloc_dst;
      end
      head <= head + IW'(nret);
      tail <= tail + IW'(do_alloc);
      cnt  <= cnt + CW'(do_alloc) - nret;
    end
  end

endmodule

// File: rtl/assoc_rename_buf_chk.sv
module assoc_rename_buf_chk #(
  parameter int DEPTH = 8,
  parameter int NSRC  = 2,
  parameter int RETW  = 2,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush,
  input logic                       alloc_full,
  input logic [NSRC-1:0]            src_hit,
  input logic [NSRC-1:0]            src_rdy,
  input logic [RETW-1:0]            ret_vld,
  input logic [NSRC-1:0][DEPTH-1:0] hitv,
  input logic [CW-1:0]              cnt
);

  for (genvar s = 0; s < NSRC; s++) begin : g_s
    p_single_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hitv[s]));
  end

  p_ready_implies_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rdy & ~src_hit) == '0);

  for (genvar k = 1; k < RETW; k++) begin : g_k
    p_retire_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_vld[k] |-> ret_vld[k-1]);
  end

  p_flush_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ret_vld == '0);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!alloc_full && src_hit == '0));

  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_full && !ret_vld[0] && !flush) |=> alloc_full);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

bind assoc_rename_buf assoc_rename_buf_chk #(.DEPTH(DEPTH), .NSRC(NSRC), .RETW(RETW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_full(alloc_full),
  .src_hit(src_hit), .src_rdy(src_rdy), .ret_vld(ret_vld), .hitv(hitv), .cnt(cnt)
);

// File: tb/assoc_rename_buf_tb.sv
module assoc_rename_buf_tb;
  localparam int D = 4, AR = 8, DW = 16, NS = 2, RW = 2, AW = 3, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, alloc_en = 0, wb_en = 0;
  logic [AW-1:0] alloc_dst = '0;
  logic [IW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_data = '0;
  logic [NS*AW-1:0] src_reg = '0;
  logic alloc_full;
  logic [IW-1:0] alloc_tag;
  logic [NS-1:0] src_hit, src_rdy;
  logic [NS*IW-1:0] src_tag;
  logic [NS*DW-1:0] src_val;
  logic [RW-1:0] ret_vld;
  logic [RW*AW-1:0] ret_reg;
  logic [RW*DW-1:0] ret_data;

  assoc_rename_buf #(.DEPTH(D), .AREGS(AR), .DW(DW), .NSRC(NS), .RETW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_en(alloc_en), .alloc_dst(alloc_dst),
    .alloc_full(alloc_full), .alloc_tag(alloc_tag), .src_reg(src_reg), .src_hit(src_hit),
    .src_rdy(src_rdy), .src_tag(src_tag), .src_val(src_val), .wb_en(wb_en), .wb_tag(wb_tag),
    .wb_data(wb_data), .ret_vld(ret_vld), .ret_reg(ret_reg), .ret_data(ret_data));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit mv[D], ml[D], mvv[D];
  int md[D], mval[D];
  int mh = 0, mt = 0, mc = 0;

  task automatic chk(string req, int act, int exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit a_en, int a_dst, bit w_en, int w_tag, int w_dat, bit fl, int s0, int s1);
    int n, sr[NS];
    bit prev, ok, a;
    alloc_en = a_en; alloc_dst = AW'(a_dst); wb_en = w_en; wb_tag = IW'(w_tag);
    wb_data = DW'(w_dat); flush = fl; src_reg = {AW'(s1), AW'(s0)};
    sr[0] = s0; sr[1] = s1;
    #1;
    chk("R2", int'(alloc_full), int'(mc == D), "full");
    chk("R2", int'(alloc_tag), mt, "alloc_tag");
    for (int s = 0; s < NS; s++) begin
      int eh, et, ev, er;
      eh = 0; et = 0; ev = 0; er = 0;
      for (int e = 0; e < D; e++)
        if (mv[e] && ml[e] && md[e] == sr[s]) begin
          eh = 1; et = e; er = int'(mvv[e]); ev = mvv[e] ? mval[e] : 0;
        end
      chk(eh == 0 ? "R6" : (er != 0 ? "R4" : "R3"), int'(src_hit[s]), eh, "hit");
      chk(eh == 0 ? "R6" : (er != 0 ? "R4" : "R3"), int'(src_rdy[s]), er, "rdy");
      chk(eh == 0 ? "R6" : "R5", int'(src_tag[s*IW +: IW]), et, "tag");
      chk("R4", int'(src_val[s*DW +: DW]), ev, "val");
    end
    n = 0; prev = !fl;
    for (int k = 0; k < RW; k++) begin
      int idx;
      idx = (mh + k) % D;
      ok = prev && mv[idx] && mvv[idx];
      chk(fl ? "R9" : "R7", int'(ret_vld[k]), int'(ok), "ret_vld");
      if (ok) begin
        chk("R7", int'(ret_reg[k*AW +: AW]), md[idx], "ret_reg");
        chk("R7", int'(ret_data[k*DW +: DW]), mval[idx], "ret_data");
        n++;
      end
      prev = ok;
    end
    @(posedge clk);
    if (fl) begin
      for (int e = 0; e < D; e++) mv[e] = 0;
      mh = 0; mt = 0; mc = 0;
    end else begin
      a = a_en && mc < D;
      if (w_en && mv[w_tag]) begin mvv[w_tag] = 1; mval[w_tag] = w_dat & 16'hffff; end
      for (int k = 0; k < n; k++) mv[(mh + k) % D] = 0;
      if (a) begin
        for (int e = 0; e < D; e++) if (mv[e] && md[e] == a_dst) ml[e] = 0;
        mv[mt] = 1; ml[mt] = 1; mvv[mt] = 0; md[mt] = a_dst;
      end
      mh = (mh + n) % D; mt = (mt + int'(a)) % D; mc = mc + int'(a) - n;
    end
    @(negedge clk);
  endtask

  task automatic look(int r);
    alloc_en = 0; wb_en = 0; flush = 0; src_reg = {AW'(0), AW'(r)};
    #1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < D; e++) begin mv[e] = 0; ml[e] = 0; mvv[e] = 0; md[e] = 0; mval[e] = 0; end
    #5;
    chk("R1", int'(alloc_full), 0, "full at reset");
    chk("R1", int'(src_hit), 0, "hit at reset");
    chk("R1", int'(ret_vld), 0, "ret at reset");
    chk("R1", int'(alloc_tag), 0, "tag at reset");
    @(negedge clk); rst_n = 1; @(negedge clk);

    cyc(1, 3, 0, 0, 0, 0, 3, 3);                 // R10: same-cycle alloc not seen
    look(3); chk("R3", int'(src_hit[0]), 1, "pending hit");
    chk("R3", int'(src_rdy[0]), 0, "pending rdy");
    cyc(1, 3, 0, 0, 0, 0, 3, 0);
    look(3); chk("R5", int'(src_tag[IW-1:0]), 1, "newest tag");
    cyc(0, 0, 1, 1, 16'hbeef, 0, 3, 0);         // R10: write not seen same cycle
    look(3); chk("R4", int'(src_val[DW-1:0]), 16'hbeef, "written value");
    chk("R7", int'(ret_vld), 0, "head not ready");
    cyc(1, 5, 0, 0, 0, 0, 0, 0);
    cyc(1, 6, 0, 0, 0, 0, 0, 0);
    chk("R2", int'(alloc_full), 1, "full after four");
    cyc(1, 7, 0, 0, 0, 0, 7, 3);
    look(7); chk("R2", int'(src_hit[0]), 0, "alloc while full ignored");
    cyc(0, 0, 1, 0, 16'h1111, 0, 3, 5);
    look(3); chk("R7", int'(ret_vld), 3, "two retire");
    chk("R7", int'(ret_data[DW-1:0]), 16'h1111, "oldest first");
    cyc(0, 0, 1, 2, 16'h5555, 0, 3, 5);
    look(3); chk("R8", int'(src_hit[0]), 0, "retired newest misses");
    chk("R7", int'(ret_vld), 1, "one retire");
    cyc(0, 0, 0, 0, 0, 1, 6, 6);
    look(6); chk("R9", int'(src_hit[0]), 0, "flushed");
    chk("R9", int'(alloc_tag), 0, "flush resets queue");
    cyc(0, 0, 1, 0, 16'h2222, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 1, 1);
    look(1); chk("R4", int'(src_rdy[0]), 0, "stale write ignored");
    @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      cyc((r % 4) != 0, (r >> 2) % 8, ((r >> 5) % 2) == 1, (r >> 6) % 4, (r >> 8) & 16'hffff,
          ((r >> 24) % 40) == 0, (r >> 3) % 8, (r >> 27) % 8);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule